// File: doc/BRIEF.md
# Receive Power-Up Offset Calibration Sequencer

This block takes a two-channel (I and Q) receive path from its sleep state to delivering valid data. When the receive enable goes high it runs a timed sequence: a fixed settling interval, a programmable first wait, an optional offset calibration and a programmable second wait. Then it raises a ready flag. All waits are counted in time units of 48 clock cycles.

During calibration the block averages the first 16 filter outputs of each channel. It stores the result as a 10-bit two's-complement offset that lines up with bits 12..3 of the 15-bit sample word. A control output tells the analog side to disconnect and short the channel inputs (internal mode), or to keep them connected so that system offsets are measured too (external mode). With calibration turned off, the offsets are loaded through write strobes instead. Once ready, each incoming sample pair has its channel offset removed, and the result is clamped to the 15-bit range.

The filter is not part of this block. Samples arrive on a data bus qualified by a valid strobe. Dropping the receive enable at any point aborts the sequence, but the offsets are kept.

Top module: `rxcal_sequencer`

## Requirements
- R1: After the clock edge that first samples `rx_en` high, the block waits 36 units (1 unit = 48 cycles), then `delay1` units, then the calibration phase if enabled, then `delay2` units. `rx_ready` goes high exactly 48·(36 + delay1 + 40·autocal + delay2) edges after that first edge.
- R2: A delay value of 0 adds no cycles at all; the sequence moves straight to the following phase.
- R3: With `autocal_en`=1 the calibration phase lasts exactly 40 units, and `cal_active` is high throughout it. With `autocal_en`=0 there is no calibration phase, and `cal_active` stays low.
- R4: `short_inputs` is high during calibration when `extcal_sel`=0 (internal mode). It stays low during calibration when `extcal_sel`=1 (external mode).
- R5: Each channel's offset is computed only from the first 16 samples with `smp_valid` high while `cal_active` is high. The offset equals floor(sum/16) shifted right by 3, which is floor(sum/128), with samples read as 15-bit two's complement. It appears on `ofs_i`/`ofs_q` one cycle after the 16th sample. Samples taken outside calibration, or after the 16th, do not affect it.
- R6: If an averaged offset falls outside −512..511, it saturates to the nearer limit and `cal_ovr` is set. `cal_ovr` is recomputed at the end of each calibration.
- R7: With `autocal_en`=0, a pulse on `ofs_wr_i`/`ofs_wr_q` loads `ofs_wdata` into that channel's offset on the next edge. With `autocal_en`=1 such writes are ignored.
- R8: The offsets keep their values while `rx_en` is low (sleep). Only `rst_n` clears them.
- R9: While `rx_ready` is high, a valid sample pair produces `out_valid` one cycle later, with out = sample − offset·8. No `out_valid` appears outside the ready state.
- R10: An output that would fall outside −16384..16383 is clamped to that limit.
- R11: When `rx_en` is low at an edge, the block returns to idle after that edge, and `rx_ready` and `cal_active` go low. A later rise of `rx_en` restarts the whole sequence from the settling interval.
- R12: After reset, `rx_ready`, `cal_active`, `short_inputs`, `cal_ovr`, `out_valid` and both offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; high wakes the path, low sends it to sleep |
| autocal_en | input | 1 | 1: run calibration in the sequence; 0: offsets are written by the user |
| extcal_sel | input | 1 | 1: calibrate with inputs connected; 0: inputs shorted |
| delay1 | input | 8 | Units waited after settling |
| delay2 | input | 8 | Units waited after calibration |
| ofs_wr_i | input | 1 | Write strobe for the I offset |
| ofs_wr_q | input | 1 | Write strobe for the Q offset |
| ofs_wdata | input | 10 | Offset value to write (two's complement) |
| smp_valid | input | 1 | Sample pair valid |
| smp_i | input | 15 | I filter output, two's complement |
| smp_q | input | 15 | Q filter output, two's complement |
| rx_ready | output | 1 | Sequence finished; corrected data flows |
| cal_active | output | 1 | Calibration phase in progress |
| short_inputs | output | 1 | Disconnect and short the analog inputs |
| cal_ovr | output | 1 | Last calibration saturated a channel offset |
| ofs_i | output | 10 | Current I offset |
| ofs_q | output | 10 | Current Q offset |
| out_valid | output | 1 | Corrected sample pair valid |
| out_i | output | 15 | Corrected I sample |
| out_q | output | 15 | Corrected Q sample |

## Verification
The ready flag is due 48·(36 + delay1 + 40·autocal + delay2) edges after the edge that first sees `rx_en` high, and calibration starts 48·(36 + delay1) edges after it. The bench counts edges from that point and samples on the falling edge both one edge before and at the computed edge, so an off-by-one in either direction shows up. Offsets are compared after the sixteenth calibration sample has been taken. A corrected sample is due one edge after it is driven, and the scoreboard queue pairs each driven sample with the next `out_valid`. Abort behaviour is checked one edge after `rx_en` falls.

// File: rtl/rxcal_pkg.sv
// Shared types for the receive calibration sequencer.
package rxcal_pkg;
    // Phases of the power-up sequence, in the order they are run.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETTLE = 3'd1,
        PH_WAIT1  = 3'd2,
        PH_CAL    = 3'd3,
        PH_WAIT2  = 3'd4,
        PH_RUN    = 3'd5
    } rx_phase_t;
endpackage

// File: rtl/rxcal_unit_timer.sv
// Unit timer: counts clock cycles inside a phase and groups them into
// units of UNIT_CYCLES. Assumes the caller pulses clear at every phase change.
module rxcal_unit_timer #(
    parameter int UNIT_CYCLES = 48,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic             unit_last,
    output logic [CNT_W-1:0] units
);
    localparam int CYC_W = $clog2(UNIT_CYCLES);

    logic [CYC_W-1:0] cyc;

    assign unit_last = (cyc == CYC_W'(UNIT_CYCLES - 1));

    // Cycle and unit counters, restarted on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cyc   <= '0;
            units <= '0;
        end else if (unit_last) begin
            cyc   <= '0;
            units <= units + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_last && !clear) |=> (units == CNT_W'($past(units) + 1'b1)));
endmodule

// File: rtl/rxcal_offset_unit.sv
// Offset holder for one channel: averages the first 2**AVG_LOG2 samples of a
// calibration phase into an OW-bit offset aligned at bit OFS_LSB, with
// saturation, or takes user writes while autocalibration is off.
// Assumes cal_on stays low outside the calibration phase.
module rxcal_offset_unit #(
    parameter int DW       = 15,
    parameter int OW       = 10,
    parameter int OFS_LSB  = 3,
    parameter int AVG_LOG2 = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_on,
    input  logic          autocal_en,
    input  logic          usr_wr,
    input  logic [OW-1:0] usr_data,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp,
    output logic [OW-1:0] ofs,
    output logic          ovr
);
    localparam int ACC_W = DW + AVG_LOG2;
    localparam int SHIFT = AVG_LOG2 + OFS_LSB;
    localparam int Q_W   = ACC_W - SHIFT;
    localparam int NSMP  = 1 << AVG_LOG2;
    localparam int CNT_W = AVG_LOG2 + 1;
    localparam logic signed [Q_W-1:0] Q_HI = Q_W'((2 ** (OW - 1)) - 1);
    localparam logic signed [Q_W-1:0] Q_LO = Q_W'(-(2 ** (OW - 1)));

    logic signed [ACC_W-1:0] acc, acc_nxt;
    logic        [CNT_W-1:0] cnt;
    logic                    take, last_take, sat_hit;
    logic signed [Q_W-1:0]   quot;
    logic        [OW-1:0]    sat_val;

    // Next sum, quotient and its clamp to the offset range.
    always_comb begin
        take      = cal_on && smp_valid && (cnt < CNT_W'(NSMP));
        last_take = take && (cnt == CNT_W'(NSMP - 1));
        acc_nxt   = acc + $signed({{AVG_LOG2{smp[DW-1]}}, smp});
        quot      = Q_W'(acc_nxt >>> SHIFT);
        sat_hit   = (quot > Q_HI) || (quot < Q_LO);
        if (quot > Q_HI)      sat_val = Q_HI[OW-1:0];
        else if (quot < Q_LO) sat_val = Q_LO[OW-1:0];
        else                  sat_val = quot[OW-1:0];
    end

    // Accumulator and sample count, held at zero outside calibration.
    always_ff @(posedge clk) begin
        if (!rst_n || !cal_on) begin
            acc <= '0;
            cnt <= '0;
        end else if (take) begin
            acc <= acc_nxt;
            cnt <= cnt + 1'b1;
        end
    end

    // Offset register: calibration result or user write; sleep leaves it alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs <= '0;
            ovr <= 1'b0;
        end else if (last_take) begin
            ofs <= sat_val;
            ovr <= sat_hit;
        end else if (!autocal_en && usr_wr) begin
            ofs <= usr_data;
        end
    end

    assert_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (autocal_en && !cal_on) |=> $stable(ofs));
    assert_ovr_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> (ofs == Q_HI[OW-1:0] || ofs == Q_LO[OW-1:0]));
endmodule

// File: rtl/rxcal_offset_sub.sv
// Output stage for one channel: removes the offset (scaled by 2**OFS_LSB)
// from each valid sample with a 15-bit clamp. One cycle of latency.
// Assumes OW + OFS_LSB < DW + 1.
module rxcal_offset_sub #(
    parameter int DW      = 15,
    parameter int OW      = 10,
    parameter int OFS_LSB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          in_valid,
    input  logic [DW-1:0] smp,
    input  logic [OW-1:0] ofs,
    output logic          out_valid,
    output logic [DW-1:0] out
);
    localparam int EXT = DW + 1 - OW - OFS_LSB;

    logic [DW:0]   diff;
    logic [DW-1:0] clamped;

    // Wide difference, then clamp on sign disagreement.
    always_comb begin
        diff = {smp[DW-1], smp} - {{EXT{ofs[OW-1]}}, ofs, {OFS_LSB{1'b0}}};
        if (diff[DW] != diff[DW-1])
            clamped = diff[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else
            clamped = diff[DW-1:0];
    end

    // Output register, loaded only while the path is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out       <= '0;
        end else begin
            out_valid <= run && in_valid;
            if (run && in_valid) out <= clamped;
        end
    end

    assert_no_out_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !out_valid);
endmodule

// File: rtl/rxcal_sequencer.sv
// Receive power-up sequencer: settle, wait, optional offset calibration,
// wait, then ready with per-channel offset removal on the I and Q samples.
// Assumes delay and mode inputs are steady while rx_en is high and that
// SETTLE_UNITS and CAL_UNITS are at least 1.
module rxcal_sequencer
    import rxcal_pkg::*;
#(
    parameter int UNIT_CYCLES  = 48,
    parameter int SETTLE_UNITS = 36,
    parameter int CAL_UNITS    = 40,
    parameter int DLY_W        = 8,
    parameter int DW           = 15,
    parameter int OW           = 10,
    parameter int OFS_LSB      = 3,
    parameter int AVG_LOG2     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             autocal_en,
    input  logic             extcal_sel,
    input  logic [DLY_W-1:0] delay1,
    input  logic [DLY_W-1:0] delay2,
    input  logic             ofs_wr_i,
    input  logic             ofs_wr_q,
    input  logic [OW-1:0]    ofs_wdata,
    input  logic             smp_valid,
    input  logic [DW-1:0]    smp_i,
    input  logic [DW-1:0]    smp_q,
    output logic             rx_ready,
    output logic             cal_active,
    output logic             short_inputs,
    output logic             cal_ovr,
    output logic [OW-1:0]    ofs_i,
    output logic [OW-1:0]    ofs_q,
    output logic             out_valid,
    output logic [DW-1:0]    out_i,
    output logic [DW-1:0]    out_q
);
    localparam int NCH   = 2;
    localparam int CNT_W = DLY_W + 1;

    rx_phase_t        phase_q, phase_d, after_wait1, after_cal;
    logic [CNT_W-1:0] units, target;
    logic             unit_last, phase_done, tmr_clear;

    logic [DW-1:0] smp_arr [NCH];
    logic [DW-1:0] out_arr [NCH];
    logic [OW-1:0] ofs_arr [NCH];
    logic          wr_arr  [NCH];
    logic [NCH-1:0] ovr_vec, vld_vec;

    // Length in units of the phase now running.
    always_comb begin
        case (phase_q)
            PH_SETTLE: target = CNT_W'(SETTLE_UNITS);
            PH_WAIT1:  target = CNT_W'(delay1);
            PH_CAL:    target = CNT_W'(CAL_UNITS);
            PH_WAIT2:  target = CNT_W'(delay2);
            default:   target = '0;
        endcase
        phase_done = unit_last && ((units + 1'b1) == target);
    end

    // Next phase, skipping phases of zero length.
    always_comb begin
        after_cal   = (delay2 != '0) ? PH_WAIT2 : PH_RUN;
        after_wait1 = autocal_en ? PH_CAL : after_cal;
        phase_d     = phase_q;
        if (!rx_en) begin
            phase_d = PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:   phase_d = PH_SETTLE;
                PH_SETTLE: if (phase_done) phase_d = (delay1 != '0) ? PH_WAIT1 : after_wait1;
                PH_WAIT1:  if (phase_done) phase_d = after_wait1;
                PH_CAL:    if (phase_done) phase_d = after_cal;
                PH_WAIT2:  if (phase_done) phase_d = PH_RUN;
                default:   phase_d = phase_q;
            endcase
        end
        tmr_clear = (phase_d != phase_q) || (phase_q == PH_IDLE) || (phase_q == PH_RUN);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    rxcal_unit_timer #(.UNIT_CYCLES(UNIT_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear),
        .unit_last(unit_last), .units(units)
    );

    assign rx_ready     = (phase_q == PH_RUN);
    assign cal_active   = (phase_q == PH_CAL);
    assign short_inputs = cal_active && !extcal_sel;

    assign smp_arr[0] = smp_i;
    assign smp_arr[1] = smp_q;
    assign wr_arr[0]  = ofs_wr_i;
    assign wr_arr[1]  = ofs_wr_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        rxcal_offset_unit #(.DW(DW), .OW(OW), .OFS_LSB(OFS_LSB), .AVG_LOG2(AVG_LOG2)) u_ofs (
            .clk(clk), .rst_n(rst_n), .cal_on(cal_active), .autocal_en(autocal_en),
            .usr_wr(wr_arr[ch]), .usr_data(ofs_wdata), .smp_valid(smp_valid),
            .smp(smp_arr[ch]), .ofs(ofs_arr[ch]), .ovr(ovr_vec[ch])
        );
        rxcal_offset_sub #(.DW(DW), .OW(OW), .OFS_LSB(OFS_LSB)) u_sub (
            .clk(clk), .rst_n(rst_n), .run(rx_ready), .in_valid(smp_valid),
            .smp(smp_arr[ch]), .ofs(ofs_arr[ch]),
            .out_valid(vld_vec[ch]), .out(out_arr[ch])
        );
    end

    assign ofs_i     = ofs_arr[0];
    assign ofs_q     = ofs_arr[1];
    assign out_i     = out_arr[0];
    assign out_q     = out_arr[1];
    assign out_valid = &vld_vec;
    assign cal_ovr   = |ovr_vec;

    assert_abort_drops_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rx_ready && !cal_active));
    assert_ready_not_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> ($past(phase_q) != PH_IDLE));
    assert_cal_needs_auto_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> autocal_en);
endmodule

// File: tb/rxcal_sequencer_test.sv
module rxcal_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, autocal_en = 1'b0, extcal_sel = 1'b0;
    logic [7:0]  delay1 = '0, delay2 = '0;
    logic        ofs_wr_i = 1'b0, ofs_wr_q = 1'b0;
    logic [9:0]  ofs_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [14:0] smp_i = '0, smp_q = '0;
    logic        rx_ready, cal_active, short_inputs, cal_ovr, out_valid;
    logic [9:0]  ofs_i, ofs_q;
    logic [14:0] out_i, out_q;

    int checks = 0, fails = 0, cyc = 0, t0 = 0;
    int exp_oi = 0, exp_oq = 0;
    int q_i[$];
    int q_q[$];
    bit finished = 1'b0;

    rxcal_sequencer uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .autocal_en(autocal_en),
        .extcal_sel(extcal_sel), .delay1(delay1), .delay2(delay2),
        .ofs_wr_i(ofs_wr_i), .ofs_wr_q(ofs_wr_q), .ofs_wdata(ofs_wdata),
        .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .rx_ready(rx_ready), .cal_active(cal_active), .short_inputs(short_inputs),
        .cal_ovr(cal_ovr), .ofs_i(ofs_i), .ofs_q(ofs_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat15(input int v);
        if (v > 16383) return 16383;
        if (v < -16384) return -16384;
        return v;
    endfunction

    function automatic int sat10(input int v);
        if (v > 511) return 511;
        if (v < -512) return -512;
        return v;
    endfunction

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic start_seq(input bit ac, input bit ext, input int d1, input int d2);
        autocal_en = ac; extcal_sel = ext; delay1 = 8'(d1); delay2 = 8'(d2);
        @(negedge clk);
        rx_en = 1'b1;
        t0 = cyc + 1;
    endtask

    task automatic stop_seq();
        rx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: one sample pair; the expected result is queued when ready.
    task automatic send(input int si, input int sq);
        smp_valid = 1'b1; smp_i = 15'(si); smp_q = 15'(sq);
        if (rx_ready) begin
            q_i.push_back(sat15(si - exp_oi * 8));
            q_q.push_back(sat15(sq - exp_oq * 8));
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic user_write(input bit sel_q, input int v);
        ofs_wdata = 10'(v);
        if (sel_q) ofs_wr_q = 1'b1; else ofs_wr_i = 1'b1;
        @(negedge clk);
        ofs_wr_i = 1'b0; ofs_wr_q = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every output pair (R9, R10).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_i.size() == 0) begin
                chk(1'b0, "R9 unexpected out_valid", 1, 0);
            end else begin
                int ei, eq;
                ei = q_i.pop_front();
                eq = q_q.pop_front();
                chk(int'($signed(out_i)) == ei, "R9/R10 out_i", int'($signed(out_i)), ei);
                chk(int'($signed(out_q)) == eq, "R9/R10 out_q", int'($signed(out_q)), eq);
            end
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
        end
    end

    initial begin
        int sum_i, sum_q;
        int vi[16];
        int vq[16];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(rx_ready == 0, "R12 rx_ready", int'(rx_ready), 0);
        chk(cal_active == 0 && short_inputs == 0, "R12 cal_active", int'(cal_active), 0);
        chk(cal_ovr == 0, "R12 cal_ovr", int'(cal_ovr), 0);
        chk(ofs_i == 0 && ofs_q == 0, "R12 offsets", int'(ofs_i), 0);
        chk(out_valid == 0, "R12 out_valid", int'(out_valid), 0);

        // R1: no calibration, delays 3 and 2
        start_seq(1'b0, 1'b0, 3, 2);
        wait_to(t0 + 48 * 36);
        chk(cal_active == 0, "R3 no cal phase when autocal off", int'(cal_active), 0);
        wait_to(t0 + 48 * 41 - 1);
        chk(rx_ready == 0, "R1 ready one edge early", int'(rx_ready), 0);
        @(negedge clk);
        chk(rx_ready == 1, "R1 ready at 41 units", int'(rx_ready), 1);

        // R7: user offsets accepted when autocal is off
        user_write(1'b0, 5);
        user_write(1'b1, -3);
        exp_oi = 5; exp_oq = -3;
        chk(int'($signed(ofs_i)) == 5, "R7 user write I", int'($signed(ofs_i)), 5);
        chk(int'($signed(ofs_q)) == -3, "R7 user write Q", int'($signed(ofs_q)), -3);
        send(1000, 1000);
        send(-200, 77);
        send(-16384, 16383);   // R10 clamps on both channels
        send(0, 0);
        @(negedge clk);

        // R11: dropping rx_en after ready
        rx_en = 1'b0;
        @(negedge clk);
        chk(rx_ready == 0, "R11 ready drops after abort", int'(rx_ready), 0);
        repeat (50) @(negedge clk);
        // R8: offsets survive sleep
        chk(int'($signed(ofs_i)) == 5, "R8 I offset kept in sleep", int'($signed(ofs_i)), 5);
        chk(int'($signed(ofs_q)) == -3, "R8 Q offset kept in sleep", int'($signed(ofs_q)), -3);

        // R11: abort in the middle of calibration, then a full restart
        start_seq(1'b1, 1'b0, 0, 0);
        wait_to(t0 + 1800);
        chk(cal_active == 1, "R3 cal running before abort", int'(cal_active), 1);
        rx_en = 1'b0;
        @(negedge clk);
        chk(cal_active == 0 && rx_ready == 0, "R11 abort leaves cal", int'(cal_active), 0);
        @(negedge clk);

        // R2/R3/R4/R5: internal calibration, zero delays
        start_seq(1'b1, 1'b0, 0, 0);
        wait_to(t0 + 100);
        send(5000, 5000);      // before calibration: ignored (R5)
        send(5000, 5000);
        wait_to(t0 + 48 * 36 - 1);
        chk(cal_active == 0, "R2 cal not yet", int'(cal_active), 0);
        @(negedge clk);
        chk(cal_active == 1, "R2 cal right after settle", int'(cal_active), 1);
        chk(short_inputs == 1, "R4 internal mode shorts inputs", int'(short_inputs), 1);
        sum_i = 0; sum_q = 0;
        for (int k = 0; k < 16; k++) begin
            vi[k] = 1000 + 10 * k;
            vq[k] = -500 - 3 * k;
            sum_i += vi[k];
            sum_q += vq[k];
            send(vi[k], vq[k]);
        end
        send(9000, 9000);      // after the 16th: ignored (R5)
        send(9000, 9000);
        exp_oi = sat10(sum_i >>> 7);
        exp_oq = sat10(sum_q >>> 7);
        chk(int'($signed(ofs_i)) == exp_oi, "R5 I average", int'($signed(ofs_i)), exp_oi);
        chk(int'($signed(ofs_q)) == exp_oq, "R5 Q average", int'($signed(ofs_q)), exp_oq);
        chk(cal_ovr == 0, "R6 no overrange", int'(cal_ovr), 0);
        wait_to(t0 + 48 * 76 - 1);
        chk(rx_ready == 0 && cal_active == 1, "R3 cal lasts 40 units", int'(rx_ready), 0);
        @(negedge clk);
        chk(rx_ready == 1 && cal_active == 0, "R1 ready after cal", int'(rx_ready), 1);
        send(0, 0);
        send(300, -300);
        user_write(1'b0, 7);   // ignored while autocal is on
        chk(int'($signed(ofs_i)) == exp_oi, "R7 write ignored in autocal", int'($signed(ofs_i)), exp_oi);
        stop_seq();

        // R4/R6: external calibration with saturating offsets
        start_seq(1'b1, 1'b1, 1, 1);
        wait_to(t0 + 48 * 37);
        chk(cal_active == 1, "R1 cal after delay1", int'(cal_active), 1);
        chk(short_inputs == 0, "R4 external mode keeps inputs", int'(short_inputs), 0);
        for (int k = 0; k < 16; k++) send(16383, -16384);
        exp_oi = 511; exp_oq = -512;
        chk(int'($signed(ofs_i)) == 511, "R6 I high clamp", int'($signed(ofs_i)), 511);
        chk(int'($signed(ofs_q)) == -512, "R6 Q low clamp", int'($signed(ofs_q)), -512);
        chk(cal_ovr == 1, "R6 overrange flag", int'(cal_ovr), 1);
        wait_to(t0 + 48 * 78 - 1);
        chk(rx_ready == 0, "R1 ready waits delay2", int'(rx_ready), 0);
        @(negedge clk);
        chk(rx_ready == 1, "R1 ready at 78 units", int'(rx_ready), 1);
        send(0, 0);
        send(-16384, 16383);   // R10 both limits
        @(negedge clk);
        stop_seq();

        // R1: maximum delays, no calibration
        start_seq(1'b0, 1'b0, 255, 255);
        wait_to(t0 + 48 * 291);
        chk(cal_active == 0, "R3 no cal with max delays", int'(cal_active), 0);
        wait_to(t0 + 48 * 546 - 1);
        chk(rx_ready == 0, "R1 max delay early", int'(rx_ready), 0);
        @(negedge clk);
        chk(rx_ready == 1, "R1 max delay ready", int'(rx_ready), 1);
        send(1234, -1234);
        @(negedge clk);
        @(negedge clk);
        chk(q_i.size() == 0, "R9 all outputs seen", q_i.size(), 0);
        summary();
    end
endmodule